// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter

A 4-bit binary counter stepped by two separate count inputs. A rising edge on the increment input adds one, and a rising edge on the decrement input subtracts one. The count wraps modulo 16 in both directions. Both count inputs are treated as asynchronous signals. A fast system clock samples each of them through a short synchronizer and turns each rising edge into a single-cycle step request.

Two level-sensitive overrides sit above the counting path, and both act without waiting for a count edge. An active-high clear forces the count to zero. An active-low load copies a 4-bit data word into the count. The block also drives two active-low terminal flags. One marks the top count while the increment input is low. The other marks zero while the decrement input is low. These flags can be used to cascade several counters.

Top module: `dual_clock_counter`

## Requirements
- R1: The count rises by exactly one for each rising edge on `inc_clk_i`. If `inc_clk_i` goes from high to low and is first sampled high again at system edge k, the count changes after system edge k+2.
- R2: The count falls by exactly one for each rising edge on `dec_clk_i`, with the same three-edge latency as R1.
- R3: Counting wraps modulo 16. Incrementing from 15 gives 0, and decrementing from 0 gives 15.
- R4: If rising edges on both count inputs are detected in the same system cycle, the count is left unchanged.
- R5: `carry_n_o` is low exactly when `count_o` equals 15 and the synchronized level of `inc_clk_i` is low; otherwise it is high. The synchronized level is the value of `inc_clk_i` sampled two system edges earlier.
- R6: `borrow_n_o` is low exactly when `count_o` equals 0 and the synchronized level of `dec_clk_i` is low; otherwise it is high.
- R7: While `load_n_i` is low, `count_o` equals `data_i` in the same cycle, and count-input edges are ignored. After `load_n_i` returns high, counting resumes from the last data value seen at a system edge.
- R8: While `clear_i` is high, `count_o` is 0 in the same cycle. Clear overrides load and both count inputs, and the count stays 0 after clear is released.
- R9: While `rst_n` is low, the count is 0, both flags are high, and both synchronizers hold a high level. A rising edge is therefore never detected as a result of reset release alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| inc_clk_i | input | 1 | Asynchronous count-up input; each rising edge adds one |
| dec_clk_i | input | 1 | Asynchronous count-down input; each rising edge subtracts one |
| load_n_i | input | 1 | Active-low parallel load override |
| data_i | input | 4 | Parallel load value |
| clear_i | input | 1 | Active-high clear override, highest priority |
| count_o | output | 4 | Current count, with the overrides applied |
| carry_n_o | output | 1 | Active-low top-count flag |
| borrow_n_o | output | 1 | Active-low zero-count flag |

## Verification
The stepping assertions rely on the two count inputs not being low at the same time, so that at most one step request appears per cycle. The stimulus therefore drops one count input while holding the other high. The only exception is one deliberate R4 sequence, in which both inputs fall and then rise together to test the coincidence rule. The load-resume assertions also rely on `data_i` being held steady across each system edge during a load. The bench changes `data_i` and the override inputs only at falling system clock edges, and releases load with the data word unchanged.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

endpackage

// File: rtl/dcc_edge_sync.sv
module dcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = async_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  // Reset to high: count inputs rest high, so no false edge after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[LAST];
    end
  end

  always_comb begin
    level_o = chain_q[LAST];
    rise_o  = chain_q[LAST] & ~prev_q;
  end

  // R1: a detected edge is a single-cycle pulse
  p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // R9: synchronizer output is high in the first cycle after reset
  p_sync_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (level_o || rst_n));

endmodule

// File: rtl/dcc_step_ctrl.sv
module dcc_step_ctrl
  import dcc_pkg::*;
(
  input  logic  up_rise_i,
  input  logic  dn_rise_i,
  input  logic  override_i,
  output step_e step_o
);

  always_comb begin
    step_o = STEP_HOLD;
    if (!override_i) begin
      unique case ({up_rise_i, dn_rise_i})
        2'b10:   step_o = STEP_INC;
        2'b01:   step_o = STEP_DEC;
        default: step_o = STEP_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/dcc_count_reg.sv
module dcc_count_reg
  import dcc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] cnt_q_o,
  output logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    unique case (step_i)
      STEP_INC: cnt_d = cnt_q + ONE;
      STEP_DEC: cnt_d = cnt_q - ONE;
      default:  cnt_d = cnt_q;
    endcase
    if (!load_n_i) cnt_d = data_i;
    if (clear_i)   cnt_d = '0;
  end

  always_comb cnt_en = clear_i | ~load_n_i | (step_i != STEP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // Overrides reach the output in the same cycle.
  always_comb begin
    if (clear_i)        count_o = '0;
    else if (!load_n_i) count_o = data_i;
    else                count_o = cnt_q;
  end

  assign cnt_q_o = cnt_q;

  p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_INC) |=> (cnt_q == WIDTH'($past(cnt_q) + ONE)));

  p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_DEC) |=> (cnt_q == WIDTH'($past(cnt_q) - ONE)));

  p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_INC && cnt_q == TOP) |=> (cnt_q == '0));

  p_wrap_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_DEC && cnt_q == '0) |=> (cnt_q == TOP));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n_i && !clear_i) |=> (cnt_q == $past(data_i)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/dcc_term.sv
module dcc_term #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  localparam logic [WIDTH-1:0] TOP = '1;

  always_comb begin
    carry_n_o  = ~((count_i == TOP) & ~up_lvl_i);
    borrow_n_o = ~((count_i == '0)  & ~dn_lvl_i);
  end

  p_carry_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n_o |-> (count_i == TOP));

  p_carry_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    up_lvl_i |-> carry_n_o);

  p_borrow_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n_o |-> (count_i == '0));

  p_borrow_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_lvl_i |-> borrow_n_o);

endmodule

// File: rtl/dual_clock_counter.sv
module dual_clock_counter
  import dcc_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_clk_i,
  input  logic             dec_clk_i,
  input  logic             load_n_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  localparam int N_SRC = 2;
  localparam int IDX_UP = 0;
  localparam int IDX_DN = 1;

  logic [N_SRC-1:0] src_raw;
  logic [N_SRC-1:0] src_lvl;
  logic [N_SRC-1:0] src_rise;
  logic             override;
  step_e            step;
  logic [CNT_W-1:0] cnt_q;

  assign src_raw[IDX_UP] = inc_clk_i;
  assign src_raw[IDX_DN] = dec_clk_i;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_sync
      dcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_raw[i]),
        .level_o (src_lvl[i]),
        .rise_o  (src_rise[i])
      );
    end
  endgenerate

  assign override = clear_i | ~load_n_i;

  dcc_step_ctrl u_step (
    .up_rise_i  (src_rise[IDX_UP]),
    .dn_rise_i  (src_rise[IDX_DN]),
    .override_i (override),
    .step_o     (step)
  );

  dcc_count_reg #(.WIDTH(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear_i),
    .load_n_i (load_n_i),
    .data_i   (data_i),
    .step_i   (step),
    .cnt_q_o  (cnt_q),
    .count_o  (count_o)
  );

  dcc_term #(.WIDTH(CNT_W)) u_term (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (count_o),
    .up_lvl_i   (src_lvl[IDX_UP]),
    .dn_lvl_i   (src_lvl[IDX_DN]),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

  p_both_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rise[IDX_UP] && src_rise[IDX_DN] && !override) |=> $stable(cnt_q));

  p_override_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    override |-> (step == STEP_HOLD));

  p_clear_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> (count_o == '0));

endmodule

// File: tb/test_dual_clock_counter.sv
module test_dual_clock_counter;

  logic       clk;
  logic       rst_n;
  logic       inc_clk_i;
  logic       dec_clk_i;
  logic       load_n_i;
  logic [3:0] data_i;
  logic       clear_i;
  logic [3:0] count_o;
  logic       carry_n_o;
  logic       borrow_n_o;

  int    n_checks;
  int    n_fail;
  string cur_req;

  // Reference model state
  int m_cnt;
  bit hu[$];
  bit hd[$];

  dual_clock_counter i_dual_clock_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_clk_i  (inc_clk_i),
    .dec_clk_i  (dec_clk_i),
    .load_n_i   (load_n_i),
    .data_i     (data_i),
    .clear_i    (clear_i),
    .count_o    (count_o),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic model_edge();
    bit ru;
    bit rd;
    if (!rst_n) begin
      m_cnt = 0;
      hu = '{1'b1, 1'b1, 1'b1};
      hd = '{1'b1, 1'b1, 1'b1};
    end else begin
      ru = hu[1] && !hu[2];
      rd = hd[1] && !hd[2];
      if (clear_i)                m_cnt = 0;
      else if (!load_n_i)         m_cnt = int'(data_i);
      else if (ru && !rd)         m_cnt = (m_cnt + 1) % 16;
      else if (rd && !ru)         m_cnt = (m_cnt + 15) % 16;
      hu.push_front(inc_clk_i);
      void'(hu.pop_back());
      hd.push_front(dec_clk_i);
      void'(hd.pop_back());
    end
  endtask

  task automatic compare();
    int e_cnt;
    bit e_carry;
    bit e_borrow;
    if (clear_i)        e_cnt = 0;
    else if (!load_n_i) e_cnt = int'(data_i);
    else                e_cnt = m_cnt;
    e_carry  = !((e_cnt == 15) && !hu[1]);
    e_borrow = !((e_cnt == 0)  && !hd[1]);
    n_checks += 3;
    if (int'(count_o) != e_cnt) begin
      n_fail++;
      $display("FAIL %s count_o actual=%0d expected=%0d t=%0t", cur_req, count_o, e_cnt, $time);
    end
    if (carry_n_o != e_carry) begin
      n_fail++;
      $display("FAIL R5 carry_n_o actual=%0b expected=%0b t=%0t", carry_n_o, e_carry, $time);
    end
    if (borrow_n_o != e_borrow) begin
      n_fail++;
      $display("FAIL R6 borrow_n_o actual=%0b expected=%0b t=%0t", borrow_n_o, e_borrow, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic pulse_up();
    inc_clk_i = 1'b0;
    repeat (3) tick();
    inc_clk_i = 1'b1;
    repeat (3) tick();
  endtask

  task automatic pulse_dn();
    dec_clk_i = 1'b0;
    repeat (3) tick();
    dec_clk_i = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    m_cnt    = 0;
    hu = '{1'b1, 1'b1, 1'b1};
    hd = '{1'b1, 1'b1, 1'b1};
    cur_req   = "R9";
    rst_n     = 1'b0;
    inc_clk_i = 1'b1;
    dec_clk_i = 1'b1;
    load_n_i  = 1'b1;
    data_i    = 4'd0;
    clear_i   = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();

    // R1, R3, R5: count up through 15 and wrap
    cur_req = "R1";
    for (int i = 0; i < 17; i++) pulse_up();

    // R2, R3, R6: count down through 0 and wrap
    cur_req = "R2";
    for (int i = 0; i < 18; i++) pulse_dn();

    // R4: coincident rising edges leave the count unchanged
    cur_req = "R4";
    inc_clk_i = 1'b0;
    dec_clk_i = 1'b0;
    repeat (3) tick();
    inc_clk_i = 1'b1;
    dec_clk_i = 1'b1;
    repeat (4) tick();

    // R7: load overrides and ignores edges, then counting resumes
    cur_req = "R7";
    load_n_i = 1'b0;
    data_i   = 4'd9;
    repeat (2) tick();
    pulse_up();
    pulse_dn();
    data_i = 4'd14;
    repeat (2) tick();
    load_n_i = 1'b1;
    tick();
    pulse_up();
    pulse_up();
    pulse_up();

    // R8: clear beats load and the count inputs
    cur_req = "R8";
    clear_i  = 1'b1;
    load_n_i = 1'b0;
    data_i   = 4'd7;
    pulse_up();
    pulse_dn();
    clear_i  = 1'b0;
    load_n_i = 1'b1;
    repeat (2) tick();
    pulse_dn();

    // R9: system reset in the middle of a count-input low phase
    cur_req = "R9";
    pulse_up();
    inc_clk_i = 1'b0;
    tick();
    rst_n = 1'b0;
    repeat (2) tick();
    inc_clk_i = 1'b1;
    tick();
    rst_n = 1'b1;
    repeat (5) tick();
    cur_req = "R1";
    pulse_up();
    pulse_up();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule